// File: doc/BRIEF.md
# Pattern-Memory CDS Timing Sequencer

This block is a small timing generator for a correlated double sampling front end. A host loads a 64-entry pattern store through a 16-bit port. Each word carries eight control levels in its low byte and an 8-bit dwell count in its high byte. The control levels drive the sampling switches (reset, DC restore, integrate, non-invert, invert), two external triggers and the ADC convert strobe.

A pulse on the start input latches the index of the last vector. Three clock cycles later the first vector reaches the outputs. The sequencer then plays the entries from address 0 up to that last index. Each entry is held for its dwell count plus one cycle, so at a 40 MHz clock a dwell of 0 lasts 25 ns and a dwell of 255 lasts 6.4 us.

When the run ends the outputs keep the last vector with its convert bit forced low, and stay there until the next run. The outputs never pass through an all-zero word between the idle value and the first vector, or between the last vector and idle.

Top module: `cdsseq_top`

## Requirements
- R1: After a synchronous active-low reset, `ctl_out` is 8'h00 and `seq_busy` is 0.
- R2: The pattern store holds 64 words of 16 bits. A word written with `host_we` at address A appears on `host_rdata` one clock after A is presented with `host_we` low.
- R3: If `seq_go` is sampled high at clock edge E while idle, `ctl_out` keeps its idle value after edges E+1 and E+2 and shows the first vector after edge E+3 (75 ns at 40 MHz).
- R4: While a vector is played, `ctl_out[7:0]` equals bits [7:0] of the stored word: bit 0 convert strobe, 1 invert, 2 non-invert, 3 integrate, 4 DC restore, 5 CDS reset, 6 external trigger 1, 7 external trigger 2.
- R5: A vector whose bits [15:8] hold D stays on `ctl_out` for exactly D+1 clock cycles.
- R6: Vectors play in address order from 0 up to the `seq_last` value sampled with the start pulse, inclusive. Later changes to `seq_last` do not affect the run.
- R7: `seq_busy` rises on the start edge and stays high until the edge at which the last vector's hold expires, where it falls.
- R8: On that final edge, `ctl_out[0]` is forced to 0 and `ctl_out[7:1]` keep the last vector's values. No other word appears between two consecutive vectors, or between a vector and the idle value.
- R9: A start pulse while `seq_busy` is high is ignored: the run's timing and contents are unchanged.
- R10: A host write during a run goes into the store. It does not alter a vector already on the outputs, and a later read returns the new word.
- R11: While idle, `ctl_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Write strobe for the pattern store |
| host_addr | input | 6 | Pattern store address for reads and writes |
| host_wdata | input | 16 | Word to write |
| host_rdata | output | 16 | Registered read data |
| seq_go | input | 1 | Start pulse |
| seq_last | input | 6 | Index of the final vector, sampled at start |
| ctl_out | output | 8 | Control levels: triggers, CDS switches, convert strobe |
| seq_busy | output | 1 | High while a run is in progress |

## Verification
A wrong vector index or a miscounted dwell shows on `ctl_out` at the very edge where a vector should change. Such an error shifts every later transition, so the bench compares the outputs on every cycle of a run against a timeline built from its own copy of the store. A faulty start-latency counter moves the first vector off edge E+3. A faulty end condition appears on the closing edge, either as a convert bit left high or as `seq_busy` falling early or late. A retrigger that is wrongly accepted restarts the timeline within three cycles and breaks the comparison there.

// File: rtl/cdsseq_pkg.sv
// Shared types for the CDS timing sequencer.
// Assumes: the control field sits in the low byte of each pattern word and the dwell field sits above it.
package cdsseq_pkg;

    // Controller states: idle, start-latency wait, vector hold
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    // Bit of the control field that carries the ADC convert strobe
    localparam int CONV_BIT = 0;

endpackage

// File: rtl/cdsseq_patmem.sv
// Pattern store for the sequencer.
// It has one write port and two read ports. The host read port is registered.
// The sequencer read port is combinational, so the next vector is ready on the edge where the current hold ends.
// Assumes: the store is small enough to build from flops; its contents are not reset.
module cdsseq_patmem #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] haddr,
    output logic [W-1:0]  hrdata,
    input  logic [AW-1:0] saddr,
    output logic [W-1:0]  sdata
);

    logic [W-1:0] store [DEPTH];
    logic [W-1:0] hrdata_q;

    // Write port: accepted at any time
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Host read port: one-cycle registered read
    always_ff @(posedge clk) begin
        hrdata_q <= store[haddr];
    end

    // Sequencer read port: combinational lookup
    always_comb begin
        sdata = store[saddr];
    end

    assign hrdata = hrdata_q;

endmodule

// File: rtl/cdsseq_ctrl.sv
// Playback controller.
// It waits START_LAT cycles after a start pulse, then applies vectors from index 0 up to the latched last index.
// Each vector is held for its dwell plus one cycle. On the last expiry it clears only the convert bit and returns to idle.
// Assumes: rd_word reflects the store at rd_idx in the same cycle; START_LAT >= 1.
module cdsseq_ctrl
    import cdsseq_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DLY_W     = 8,
    parameter int CTL_W     = 8,
    parameter int START_LAT = 3,
    localparam int W        = DLY_W + CTL_W,
    localparam int WC_W     = $clog2(START_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [AW-1:0]    last_idx,
    input  logic [W-1:0]     rd_word,
    output logic [AW-1:0]    rd_idx,
    output logic [CTL_W-1:0] ctl_out,
    output logic             busy
);

    seq_state_t       state;
    logic [WC_W-1:0]  wcnt;
    logic [DLY_W-1:0] dcnt;
    logic [AW-1:0]    cur_idx;
    logic [AW-1:0]    last_q;
    logic [CTL_W-1:0] ctl_q;
    logic             at_last;

    // Address of the vector to apply next
    always_comb begin
        rd_idx  = (state == ST_ARM) ? '0 : cur_idx + AW'(1);
        at_last = (cur_idx == last_q);
    end

    // Main sequencing process: start latency, apply, hold, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            dcnt    <= '0;
            cur_idx <= '0;
            last_q  <= '0;
            ctl_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state  <= ST_ARM;
                        wcnt   <= WC_W'(START_LAT - 1);
                        last_q <= last_idx;
                    end
                end
                ST_ARM: begin
                    if (wcnt == '0) begin
                        ctl_q   <= rd_word[CTL_W-1:0];
                        dcnt    <= rd_word[CTL_W +: DLY_W];
                        cur_idx <= '0;
                        state   <= ST_HOLD;
                    end else begin
                        wcnt <= wcnt - WC_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (dcnt != '0) begin
                        dcnt <= dcnt - DLY_W'(1);
                    end else if (at_last) begin
                        ctl_q[CONV_BIT] <= 1'b0;
                        state           <= ST_IDLE;
                    end else begin
                        ctl_q   <= rd_word[CTL_W-1:0];
                        dcnt    <= rd_word[CTL_W +: DLY_W];
                        cur_idx <= rd_idx;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ctl_out = ctl_q;
    assign busy    = (state != ST_IDLE);

    // R8
    conv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctl_out[CONV_BIT]);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ctl_out));

    // R3
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $stable(ctl_out));

    // R5
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && dcnt != '0) |=> ($stable(ctl_out) && busy));

    // R9
    retrig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && dcnt != '0 && trig) |=> (busy && $stable(last_q)));

    // R7
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> busy);

endmodule

// File: rtl/cdsseq_top.sv
// Top level of the CDS timing sequencer.
// It joins the pattern store to the playback controller. Host writes go straight into the store at any time.
// Assumes: a 40 MHz clock, so START_LAT = 3 gives 75 ns from start to first vector.
module cdsseq_top #(
    parameter int DEPTH     = 64,
    parameter int DLY_W     = 8,
    parameter int CTL_W     = 8,
    parameter int START_LAT = 3,
    localparam int AW       = $clog2(DEPTH),
    localparam int W        = DLY_W + CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [W-1:0]     host_wdata,
    output logic [W-1:0]     host_rdata,
    input  logic             seq_go,
    input  logic [AW-1:0]    seq_last,
    output logic [CTL_W-1:0] ctl_out,
    output logic             seq_busy
);

    logic [AW-1:0] seq_rd_idx;
    logic [W-1:0]  seq_rd_word;

    cdsseq_patmem #(
        .DEPTH (DEPTH),
        .W     (W)
    ) u_mem (
        .clk    (clk),
        .we     (host_we),
        .waddr  (host_addr),
        .wdata  (host_wdata),
        .haddr  (host_addr),
        .hrdata (host_rdata),
        .saddr  (seq_rd_idx),
        .sdata  (seq_rd_word)
    );

    cdsseq_ctrl #(
        .AW        (AW),
        .DLY_W     (DLY_W),
        .CTL_W     (CTL_W),
        .START_LAT (START_LAT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (seq_go),
        .last_idx (seq_last),
        .rd_word  (seq_rd_word),
        .rd_idx   (seq_rd_idx),
        .ctl_out  (ctl_out),
        .busy     (seq_busy)
    );

endmodule

// File: tb/cdsseq_top_tb.sv
// Bench for cdsseq_top: seeded random patterns plus directed corner runs.
// Every cycle of each run is compared against a timeline computed from a bench copy of the store.
module cdsseq_top_tb;

    localparam int CLK_PERIOD = 25;
    localparam int MAXT       = 16400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we;
    logic [5:0]  host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        seq_go;
    logic [5:0]  seq_last;
    logic [7:0]  ctl_out;
    logic        seq_busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] mdl [64];
    logic [7:0]  exp_ctl  [MAXT];
    logic        exp_busy [MAXT];
    logic [7:0]  idle_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdsseq_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .seq_go     (seq_go),
        .seq_last   (seq_last),
        .ctl_out    (ctl_out),
        .seq_busy   (seq_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] rand_word(input int maxd);
        logic [15:0] w;
        w[7:0]  = 8'($urandom);
        w[15:8] = 8'($urandom_range(0, maxd));
        return w;
    endfunction

    task automatic host_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mdl[a] = d;
    endtask

    // R2: registered read, one cycle after the address
    task automatic host_read_chk(input logic [5:0] a, input string req);
        @(negedge clk);
        host_we = 1'b0; host_addr = a;
        @(negedge clk);
        check(host_rdata == mdl[a], req, host_rdata, mdl[a]);
    endtask

    // Expected per-edge timeline: 3 latency entries, vectors, finish, then idle hold
    task automatic build_exp(input logic [5:0] last, output int n);
        int t = 0;
        for (int k = 0; k < 3; k++) begin
            exp_ctl[t] = idle_val; exp_busy[t] = 1'b1; t++;
        end
        for (int j = 0; j <= int'(last); j++) begin
            for (int c = 0; c <= int'(mdl[j][15:8]); c++) begin
                exp_ctl[t] = mdl[j][7:0]; exp_busy[t] = 1'b1; t++;
            end
        end
        exp_ctl[t] = mdl[last][7:0] & 8'hFE; exp_busy[t] = 1'b0; t++;
        for (int k = 0; k < 3; k++) begin
            exp_ctl[t] = exp_ctl[t-1]; exp_busy[t] = 1'b0; t++;
        end
        n = t;
    endtask

    // One run; optional retrigger and store write at given timeline indexes (-1 = none)
    task automatic run_seq(input logic [5:0] last, input int retrig_at, input int wr_at,
                           input logic [15:0] wr_val, input string req);
        int n;
        int fin;
        int bad_t = -1;
        logic [7:0] act_c = 0, exp_c = 0;
        logic act_b = 0, exp_b = 0;
        build_exp(last, n);
        fin = n - 4;
        @(negedge clk);
        seq_last = last; seq_go = 1'b1;
        @(negedge clk);
        seq_go = 1'b0;
        seq_last = 6'($urandom);
        for (int t = 0; t < n; t++) begin
            if (bad_t < 0 && (ctl_out !== exp_ctl[t] || seq_busy !== exp_busy[t])) begin
                bad_t = t; act_c = ctl_out; exp_c = exp_ctl[t];
                act_b = seq_busy; exp_b = exp_busy[t];
            end
            seq_go  = (t == retrig_at && t < fin);
            host_we = (t == wr_at);
            host_addr = 6'd0; host_wdata = wr_val;
            @(negedge clk);
        end
        host_we = 1'b0; seq_go = 1'b0;
        if (wr_at >= 0) mdl[0] = wr_val;
        total++;
        if (bad_t >= 0) begin
            bad++;
            $display("FAIL %s at t=%0d actual ctl=%0h busy=%0b expected ctl=%0h busy=%0b",
                     req, bad_t, act_c, act_b, exp_c, exp_b);
        end
        idle_val = exp_ctl[n-1];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        seq_go = 1'b0; seq_last = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ctl_out == 8'h00, "R1 ctl", ctl_out, 0);
        check(seq_busy == 1'b0, "R1 busy", seq_busy, 0);
        rst_n = 1'b1;
        idle_val = 8'h00;

        // R2: load every word and read a sample back
        for (int i = 0; i < 64; i++) host_write(6'(i), rand_word(4));
        for (int i = 0; i < 64; i += 7) host_read_chk(6'(i), "R2 readback");
        host_write(6'd63, 16'hA55A);
        host_read_chk(6'd63, "R2 top address");

        // R3 R4 R5: single vector with zero dwell, all control bits set
        host_write(6'd0, 16'h00FF);
        run_seq(6'd0, -1, -1, 16'h0, "R3 R4 R5 R8 single vector");

        // R8: last vector has convert set, the idle value keeps the other bits
        host_write(6'd0, 16'h0281);
        host_write(6'd1, 16'h0101);
        run_seq(6'd1, -1, -1, 16'h0, "R8 convert cleared");
        check(ctl_out == 8'h00, "R8 idle value", ctl_out, 8'h00);

        // R5: maximum dwell
        host_write(6'd0, 16'hFF5A);
        host_write(6'd1, 16'h00A5);
        run_seq(6'd1, -1, -1, 16'h0, "R5 dwell 255");

        // R6: full store, zero dwell everywhere
        for (int i = 0; i < 64; i++) host_write(6'(i), {8'h00, 8'(i * 37 + 1)});
        run_seq(6'd63, -1, -1, 16'h0, "R6 full length");

        // R9: retrigger during run is ignored
        for (int i = 0; i < 64; i++) host_write(6'(i), rand_word(3));
        run_seq(6'd9, 6, -1, 16'h0, "R9 retrigger ignored");
        run_seq(6'd5, 2, -1, 16'h0, "R9 retrigger during start wait");

        // R10: write to address 0 while it is playing or done
        run_seq(6'd7, 5, 4, 16'h33CC, "R10 write during run");
        host_read_chk(6'd0, "R10 new word stored");
        run_seq(6'd3, -1, -1, 16'h0, "R10 new word used by next run");

        // R11: idle hold across a gap with host traffic
        repeat (5) @(negedge clk);
        check(ctl_out == idle_val, "R11 idle hold", ctl_out, idle_val);
        check(seq_busy == 1'b0, "R11 busy low", seq_busy, 0);

        // Random runs: R4 R5 R6 R7 R8
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < 64; i++) mdl[i] = mdl[i];
            for (int i = 0; i < 16; i++) host_write(6'($urandom), rand_word(5));
            run_seq(6'($urandom_range(0, 40)), -1, -1, 16'h0, "R7 random run");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule